// File: doc/BRIEF.md
# Segmented Event Ring Producer

This block places 16-byte event records into a circular ring held in memory. The ring is a chain of segments. A segment table, also in memory, gives each segment's start address and its length in records. Software sets three values: the table length, the table start address and the consumer's dequeue pointer. Events arrive on a valid/ready stream. The block reads table entries through a single-beat read port and stores records through a 32-bit word write port. Each store waits for the previous one to be acknowledged.

A record is stored in two phases. First all four words go out with the ownership (cycle) bit inverted. Then the last word is rewritten with the true cycle bit, so a consumer never sees a half-written record as valid. The cycle bit flips each time the producer passes through the whole table. When only one slot remains in the current segment, fullness is judged against the start of the next segment. For that test the block keeps a cached copy of the next segment's base, fetched right after each segment load.

Back-pressure: `ev_ready` is high only when no table fetch or record store is in progress and no fetch is waiting to start. A transfer happens on a clock edge where `ev_valid` and `ev_ready` are both high. An event that cannot be stored is still consumed, and it is reported by a one-cycle reject pulse.

Top module: `ering_producer`

## Requirements
- R1: After reset the phase bit is 1, the enqueue pointer is 0, `sts_empty`=1, `sts_uninit`=1, `sts_full`=0, both error flags are 0 and `ev_ready`=1.
- R2: An event taken while the table length, the table address or the enqueue pointer is zero writes nothing. `rej_uninit` pulses in the cycle after the transfer.
- R3: An accepted record with words w0..w3 (w0 at the lowest address) produces five writes in order: w0..w3 to enqueue+0, +4, +8, +12, with bit 0 of w3 set to the inverse of the phase bit, then w3 to enqueue+12 with bit 0 equal to the phase bit. Each write holds request, address and data until acknowledged, and the next is issued only after that acknowledge.
- R4: The read and write ports are never requested together. Table entry i is read at table address + 16*i. Entry bits [63:0] hold the segment base, of which the low address-width bits are used, and bits [79:64] hold the segment length in records.
- R5: `ev_ready` is low while a fetch or a record store is outstanding or pending.
- R6: After each record the enqueue pointer advances by 16 and the slot count drops by one. At zero the segment index advances. If the index reaches the table length it returns to 0 and the phase bit toggles. The new segment's entry then reloads the enqueue pointer and the slot count.
- R7: `sts_empty` is 1 exactly when the enqueue pointer equals the dequeue pointer.
- R8: With one slot left, `sts_full` is 1 when the dequeue pointer equals the next segment's base (index+1 modulo table length). Otherwise it is 1 when the dequeue pointer equals enqueue+16. An event taken while full writes nothing, and `rej_full` pulses in the cycle after the transfer.
- R9: Writing the table length or address starts a fetch of the current entry only when both values are then nonzero.
- R10: If a table write leaves the current index greater than the table length, `err_idx` is set and no fetch is made.
- R11: An error response on either port sets the sticky `err_mem`, and the record in progress does not advance the ring. `err_clr` clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size_we | input | 1 | Write strobe for the table length |
| cfg_size | input | IW | Table length in entries |
| cfg_base_we | input | 1 | Write strobe for the table address |
| cfg_base | input | AW | Table start address |
| cfg_deq_we | input | 1 | Write strobe for the dequeue pointer |
| cfg_deq | input | AW | Consumer dequeue pointer |
| err_clr | input | 1 | Clears both error flags |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block can take an event |
| ev_data | input | DW*WORDS | Record, word 0 in the low bits |
| rd_req | output | 1 | Table read request |
| rd_addr | output | AW | Table entry address |
| rd_ack | input | 1 | Read completed, data valid |
| rd_err | input | 1 | Read error, valid with rd_ack |
| rd_data | input | 128 | Table entry contents |
| wr_req | output | 1 | Word write request |
| wr_addr | output | AW | Word write address |
| wr_data | output | DW | Word write data |
| wr_ack | input | 1 | Write completed |
| wr_err | input | 1 | Write error, valid with wr_ack |
| sts_empty | output | 1 | Ring empty |
| sts_full | output | 1 | Ring full |
| sts_uninit | output | 1 | Ring not configured |
| sts_phase | output | 1 | Current producer phase bit |
| sts_enq | output | AW | Current enqueue pointer |
| rej_full | output | 1 | Pulse: event dropped, ring full |
| rej_uninit | output | 1 | Pulse: event dropped, ring not configured |
| err_mem | output | 1 | Sticky memory error flag |
| err_idx | output | 1 | Sticky bad table index flag |

## Verification
The producer is driven through a full pass over a three-segment table of unequal lengths, 3, 2 and 3 records. This separates a correct per-segment reload from a ring that simply assumes one fixed stride. A run of events that reaches the last slot, with the consumer parked at segment 0, tells the next-segment fullness rule apart from the plain enqueue+16 rule. After the wrap, a second fill shows the phase bit inverting in both write phases. Events sent before configuration, an injected write error, and a table shrink below the current index each show that the rejected or failed path leaves the pointer, the phase and the write stream untouched.

// File: rtl/ering_pkg.sv
package ering_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_FETCH_CUR,
    ST_FETCH_NXT
  } ering_state_e;

  localparam int ENTRY_W   = 128;
  localparam int ENTRY_B   = 16;
  localparam int SIZE_LSB  = 64;
  localparam int CYC_BIT   = 0;
endpackage

// File: rtl/ering_tbl_fetch.sv
module ering_tbl_fetch #(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [IW-1:0]               idx,
  input  logic [AW-1:0]               tbl_base,
  output logic                        rd_req,
  output logic [AW-1:0]               rd_addr,
  input  logic                        rd_ack,
  input  logic                        rd_err,
  input  logic [ering_pkg::ENTRY_W-1:0] rd_data,
  output logic                        done,
  output logic                        err,
  output logic [AW-1:0]               seg_base,
  output logic [IW-1:0]               seg_size
);
  import ering_pkg::*;

  logic unused_bits;
  assign unused_bits = ^{rd_data[ENTRY_W-1:SIZE_LSB+IW], rd_data[SIZE_LSB-1:AW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      seg_base <= '0;
      seg_size <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rd_req  <= 1'b1;
        rd_addr <= tbl_base + AW'(idx) * AW'(ENTRY_B);
      end else if (rd_req && rd_ack) begin
        rd_req   <= 1'b0;
        done     <= 1'b1;
        err      <= rd_err;
        seg_base <= rd_data[AW-1:0];
        seg_size <= rd_data[SIZE_LSB +: IW];
      end
    end
  end
endmodule

// File: rtl/ering_rec_writer.sv
module ering_rec_writer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-1:0]         base,
  input  logic [DW*WORDS-1:0]   rec,
  input  logic                  phase,
  output logic                  wr_req,
  output logic [AW-1:0]         wr_addr,
  output logic [DW-1:0]         wr_data,
  input  logic                  wr_ack,
  input  logic                  wr_err,
  output logic                  done,
  output logic                  err
);
  import ering_pkg::*;

  localparam int SW   = $clog2(WORDS + 1);
  localparam int IXW  = $clog2(WORDS);
  localparam int LAST = WORDS - 1;
  localparam int BPW  = DW / 8;

  logic [SW-1:0]        step;
  logic [AW-1:0]        base_q;
  logic [DW*WORDS-1:0]  rec_q;
  logic                 ph_q;
  logic [DW-1:0]        words [WORDS];
  logic                 final_ph;
  logic [IXW-1:0]       wsel;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = rec_q[g*DW +: DW];
  end

  assign final_ph = (step == SW'(WORDS));
  assign wsel     = final_ph ? IXW'(LAST) : step[IXW-1:0];
  assign wr_addr  = base_q + AW'(wsel) * AW'(BPW);

  always_comb begin
    wr_data = words[wsel];
    if (wsel == IXW'(LAST)) wr_data[CYC_BIT] = final_ph ? ph_q : ~ph_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_req <= 1'b0;
      step   <= '0;
      base_q <= '0;
      rec_q  <= '0;
      ph_q   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        wr_req <= 1'b1;
        step   <= '0;
        base_q <= base;
        rec_q  <= rec;
        ph_q   <= phase;
      end else if (wr_req && wr_ack) begin
        if (wr_err || final_ph) begin
          wr_req <= 1'b0;
          done   <= 1'b1;
          err    <= wr_err;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ering_status.sv
module ering_status #(
  parameter int AW    = 32,
  parameter int IW    = 16,
  parameter int REC_B = 16
) (
  input  logic [AW-1:0] enq,
  input  logic [AW-1:0] deq,
  input  logic [IW-1:0] cnt,
  input  logic [AW-1:0] nxt_base,
  input  logic [IW-1:0] tbl_size,
  input  logic [AW-1:0] tbl_base,
  output logic          empty,
  output logic          full,
  output logic          uninit
);
  assign empty  = (enq == deq);
  assign uninit = (tbl_size == '0) || (tbl_base == '0) || (enq == '0);
  assign full   = (cnt == IW'(1)) ? (deq == nxt_base)
                                  : (deq == enq + AW'(REC_B));
endmodule

// File: rtl/ering_producer.sv
module ering_producer #(
  parameter int AW    = 32,
  parameter int IW    = 16,
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_size_we,
  input  logic [IW-1:0]               cfg_size,
  input  logic                        cfg_base_we,
  input  logic [AW-1:0]               cfg_base,
  input  logic                        cfg_deq_we,
  input  logic [AW-1:0]               cfg_deq,
  input  logic                        err_clr,
  input  logic                        ev_valid,
  output logic                        ev_ready,
  input  logic [DW*WORDS-1:0]         ev_data,
  output logic                        rd_req,
  output logic [AW-1:0]               rd_addr,
  input  logic                        rd_ack,
  input  logic                        rd_err,
  input  logic [ering_pkg::ENTRY_W-1:0] rd_data,
  output logic                        wr_req,
  output logic [AW-1:0]               wr_addr,
  output logic [DW-1:0]               wr_data,
  input  logic                        wr_ack,
  input  logic                        wr_err,
  output logic                        sts_empty,
  output logic                        sts_full,
  output logic                        sts_uninit,
  output logic                        sts_phase,
  output logic [AW-1:0]               sts_enq,
  output logic                        rej_full,
  output logic                        rej_uninit,
  output logic                        err_mem,
  output logic                        err_idx
);
  import ering_pkg::*;

  localparam int REC_B = (DW / 8) * WORDS;

  ering_state_e  st;
  logic [IW-1:0] tbl_size, seg_idx, cnt, idx_p1, idx_inc, size_nx, f_idx, f_size;
  logic [AW-1:0] tbl_base, deq, enq, nxt_base, base_nx, f_base;
  logic          phase, fetch_pend;
  logic          hs, w_start, w_done, w_err, f_start, f_done, f_err;
  logic          cfg_hit, reconf, bad_idx;

  assign size_nx = cfg_size_we ? cfg_size : tbl_size;
  assign base_nx = cfg_base_we ? cfg_base : tbl_base;
  assign cfg_hit = (cfg_size_we || cfg_base_we) && (size_nx != '0) && (base_nx != '0);
  assign bad_idx = seg_idx > size_nx;
  assign reconf  = cfg_hit && !bad_idx;

  assign idx_p1  = seg_idx + 1'b1;
  assign idx_inc = (idx_p1 == tbl_size) ? '0 : idx_p1;

  assign ev_ready = (st == ST_IDLE) && !fetch_pend;
  assign hs       = ev_valid && ev_ready;
  assign w_start  = hs && !sts_uninit && !sts_full;

  assign f_start = ((st == ST_IDLE) && fetch_pend)
                || ((st == ST_WRITE) && w_done && !w_err && (cnt == IW'(1)))
                || ((st == ST_FETCH_CUR) && f_done && !f_err);
  assign f_idx   = (st == ST_IDLE) ? seg_idx : idx_inc;

  assign sts_phase = phase;
  assign sts_enq   = enq;

  ering_status #(.AW(AW), .IW(IW), .REC_B(REC_B)) u_status (
    .enq(enq), .deq(deq), .cnt(cnt), .nxt_base(nxt_base),
    .tbl_size(tbl_size), .tbl_base(tbl_base),
    .empty(sts_empty), .full(sts_full), .uninit(sts_uninit)
  );

  ering_tbl_fetch #(.AW(AW), .IW(IW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(f_start), .idx(f_idx), .tbl_base(tbl_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
    .rd_data(rd_data), .done(f_done), .err(f_err),
    .seg_base(f_base), .seg_size(f_size)
  );

  ering_rec_writer #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_writer (
    .clk(clk), .rst_n(rst_n), .start(w_start), .base(enq), .rec(ev_data),
    .phase(phase), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_err(wr_err), .done(w_done), .err(w_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      tbl_size   <= '0;
      tbl_base   <= '0;
      deq        <= '0;
      enq        <= '0;
      cnt        <= '0;
      seg_idx    <= '0;
      nxt_base   <= '0;
      phase      <= 1'b1;
      fetch_pend <= 1'b0;
      rej_full   <= 1'b0;
      rej_uninit <= 1'b0;
      err_mem    <= 1'b0;
      err_idx    <= 1'b0;
    end else begin
      rej_uninit <= hs && sts_uninit;
      rej_full   <= hs && !sts_uninit && sts_full;
      if (cfg_size_we) tbl_size <= cfg_size;
      if (cfg_base_we) tbl_base <= cfg_base;
      if (cfg_deq_we)  deq      <= cfg_deq;
      if (err_clr) begin
        err_mem <= 1'b0;
        err_idx <= 1'b0;
      end
      if (cfg_hit && bad_idx) err_idx <= 1'b1;
      if ((st == ST_IDLE) && fetch_pend) fetch_pend <= 1'b0;
      if (reconf) fetch_pend <= 1'b1;

      unique case (st)
        ST_IDLE: begin
          if (fetch_pend)   st <= ST_FETCH_CUR;
          else if (w_start) st <= ST_WRITE;
        end
        ST_WRITE: begin
          if (w_done) begin
            if (w_err) begin
              err_mem <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              enq <= enq + AW'(REC_B);
              cnt <= cnt - 1'b1;
              if (cnt == IW'(1)) begin
                seg_idx <= idx_inc;
                if (idx_inc == '0) phase <= ~phase;
                st <= ST_FETCH_CUR;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
        end
        ST_FETCH_CUR: begin
          if (f_done) begin
            if (f_err) begin
              err_mem <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              enq <= f_base;
              cnt <= f_size;
              st  <= ST_FETCH_NXT;
            end
          end
        end
        ST_FETCH_NXT: begin
          if (f_done) begin
            if (f_err) err_mem  <= 1'b1;
            else       nxt_base <= f_base;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ering_producer_chk.sv
module ering_producer_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic          rd_req,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          sts_full,
  input logic          sts_uninit,
  input logic          sts_phase,
  input logic          rej_full,
  input logic          rej_uninit
);
  // R4: one port at a time
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && rd_req));

  // R5: no acceptance while memory traffic is outstanding
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || rd_req) |-> !ev_ready);

  // R3: write request held stable until acknowledged
  a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R2: unconfigured ring drops the event
  a_r2_uninit_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && sts_uninit) |=> (rej_uninit && !wr_req));

  // R8: full ring drops the event
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !sts_uninit && sts_full) |=> (rej_full && !wr_req));

  // R6: phase toggles only together with a segment fetch
  a_r6_phase_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sts_phase) |-> rd_req);
endmodule

bind ering_producer ering_producer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .rd_req(rd_req), .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr),
  .wr_data(wr_data), .sts_full(sts_full), .sts_uninit(sts_uninit),
  .sts_phase(sts_phase), .rej_full(rej_full), .rej_uninit(rej_uninit)
);

// File: tb/test_ering_producer.sv
module test_ering_producer;
  localparam int AW = 32;
  localparam int IW = 16;
  localparam int DW = 32;
  localparam int WORDS = 4;
  localparam logic [31:0] TBASE = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_size_we = 0, cfg_base_we = 0, cfg_deq_we = 0, err_clr = 0;
  logic [IW-1:0] cfg_size = '0;
  logic [AW-1:0] cfg_base = '0, cfg_deq = '0;
  logic ev_valid = 0;
  logic ev_ready;
  logic [DW*WORDS-1:0] ev_data = '0;
  logic rd_req, rd_ack = 0, rd_err = 0;
  logic [AW-1:0] rd_addr;
  logic [127:0] rd_data = '0;
  logic wr_req, wr_ack = 0, wr_err = 0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic sts_empty, sts_full, sts_uninit, sts_phase, rej_full, rej_uninit, err_mem, err_idx;
  logic [AW-1:0] sts_enq;

  always #4 clk = ~clk;

  ering_producer #(.AW(AW), .IW(IW), .DW(DW), .WORDS(WORDS)) i_ering_producer (
    .clk(clk), .rst_n(rst_n), .cfg_size_we(cfg_size_we), .cfg_size(cfg_size),
    .cfg_base_we(cfg_base_we), .cfg_base(cfg_base), .cfg_deq_we(cfg_deq_we),
    .cfg_deq(cfg_deq), .err_clr(err_clr), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_data(ev_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_err(rd_err), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err), .sts_empty(sts_empty),
    .sts_full(sts_full), .sts_uninit(sts_uninit), .sts_phase(sts_phase),
    .sts_enq(sts_enq), .rej_full(rej_full), .rej_uninit(rej_uninit),
    .err_mem(err_mem), .err_idx(err_idx)
  );

  int nchk = 0, nerr = 0, nreads = 0, both_seen = 0;
  bit done_flag = 0;
  bit chk_wr = 1, inj_err = 0;
  logic [63:0] exp_q[$];

  // behavioural model of the ring
  logic [31:0] sbase[3] = '{32'h400, 32'h800, 32'hC00};
  int          ssize[3] = '{3, 2, 3};
  int m_size = 0, m_cnt = 0, m_idx = 0;
  logic [31:0] m_base = 0, m_deq = 0, m_enq = 0;
  bit m_phase = 1, m_errmem = 0, m_erridx = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  function automatic bit m_uninit();
    return (m_size == 0) || (m_base == 0) || (m_enq == 0);
  endfunction

  function automatic bit m_full();
    if (m_cnt == 1 && m_size != 0) return m_deq == sbase[(m_idx + 1) % m_size];
    return m_deq == m_enq + 32'd16;
  endfunction

  function automatic void m_load();
    m_enq = sbase[m_idx];
    m_cnt = ssize[m_idx];
  endfunction

  function automatic void m_reconf();
    if (m_size != 0 && m_base != 0) begin
      if (m_idx > m_size) m_erridx = 1;
      else m_load();
    end
  endfunction

  function automatic logic [DW*WORDS-1:0] mk(input int k);
    logic [31:0] w0, w1, w2, w3;
    w0 = 32'h1000_0000 + k; w1 = 32'h2200_0000 + k;
    w2 = 32'h3330_0000 + k; w3 = 32'hC0DE_0000 | k;
    return {w3, w2, w1, w0};
  endfunction

  // memory responders
  initial forever begin
    @(negedge clk);
    if (wr_req && rd_req) both_seen++;
    if (wr_ack) begin
      wr_ack = 0; wr_err = 0;
    end else if (wr_req) begin
      if (chk_wr) begin
        if (exp_q.size() == 0) begin
          nchk++; nerr++;
          $display("FAIL R3: actual write %0h:%0h expected none", wr_addr, wr_data);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk("R3 write addr/data", {wr_addr, wr_data}, e);
        end
      end
      wr_ack = 1; wr_err = inj_err; inj_err = 0;
    end
    if (rd_ack) begin
      rd_ack = 0;
    end else if (rd_req) begin
      int ix;
      ix = int'((rd_addr - TBASE) >> 4);
      nreads++;
      if (rd_addr < TBASE || rd_addr[3:0] != 0 || ix > 2) begin
        nchk++; nerr++;
        $display("FAIL R4: actual read addr %0h expected table entry", rd_addr);
        rd_data = '0;
      end else begin
        rd_data = {48'h0, 16'(ssize[ix]), 32'h0, sbase[ix]};
      end
      rd_ack = 1;
    end
  end

  initial begin
    #(8 * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
  endtask

  task automatic cmp(input string tag);
    chk({tag, " R7 empty"}, sts_empty, m_enq == m_deq);
    chk({tag, " R8 full"}, sts_full, m_full());
    chk({tag, " R2 uninit"}, sts_uninit, m_uninit());
    chk({tag, " R6 phase"}, sts_phase, m_phase);
    chk({tag, " R6 enq"}, sts_enq, m_enq);
    chk({tag, " R11 err_mem"}, err_mem, m_errmem);
    chk({tag, " R10 err_idx"}, err_idx, m_erridx);
    chk({tag, " R4 ports exclusive"}, both_seen, 0);
  endtask

  task automatic set_size(input int v);
    @(negedge clk); cfg_size = IW'(v); cfg_size_we = 1;
    @(negedge clk); cfg_size_we = 0;
    m_size = v; m_reconf();
    wait_idle();
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); cfg_base = v; cfg_base_we = 1;
    @(negedge clk); cfg_base_we = 0;
    m_base = v; m_reconf();
    wait_idle();
  endtask

  task automatic set_deq(input logic [31:0] v);
    @(negedge clk); cfg_deq = v; cfg_deq_we = 1;
    @(negedge clk); cfg_deq_we = 0;
    m_deq = v;
  endtask

  task automatic send(input int k, input bit inject);
    logic [DW*WORDS-1:0] rec;
    logic [31:0] w3m;
    bit exp_u, exp_f, acc;
    rec = mk(k);
    exp_u = m_uninit();
    exp_f = !exp_u && m_full();
    acc = !exp_u && !exp_f;
    if (acc && !inject) begin
      w3m = rec[127:96] & ~32'h1;
      for (int j = 0; j < 3; j++) exp_q.push_back({m_enq + 32'(4*j), rec[j*32 +: 32]});
      exp_q.push_back({m_enq + 32'd12, w3m | {31'h0, ~m_phase}});
      exp_q.push_back({m_enq + 32'd12, w3m | {31'h0, m_phase}});
    end
    if (inject) begin chk_wr = 0; inj_err = 1; end
    @(negedge clk); ev_data = rec; ev_valid = 1;
    @(negedge clk); ev_valid = 0;
    chk("R2 rej_uninit pulse", rej_uninit, exp_u);
    chk("R8 rej_full pulse", rej_full, exp_f);
    chk("R5 ready after transfer", ev_ready, !acc);
    if (acc) wait_idle();
    chk("R3 all writes issued", exp_q.size(), 0);
    if (acc && inject) begin
      m_errmem = 1; chk_wr = 1;
    end else if (acc) begin
      m_enq = m_enq + 32'd16; m_cnt--;
      if (m_cnt == 0) begin
        m_idx++;
        if (m_idx == m_size) begin m_idx = 0; m_phase = ~m_phase; end
        m_load();
      end
    end
    cmp($sformatf("ev%0d", k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready", ev_ready, 1);
    chk("R1 phase", sts_phase, 1);
    chk("R1 enq", sts_enq, 0);
    chk("R1 empty", sts_empty, 1);
    chk("R1 uninit", sts_uninit, 1);
    chk("R1 full", sts_full, 0);
    chk("R1 errors", {err_mem, err_idx}, 0);
    // R2: event before configuration
    send(0, 0);
    // R9: length alone starts no fetch
    set_size(3);
    chk("R9 no fetch with zero base", nreads, 0);
    set_base(TBASE);
    chk("R9 fetch current and next", nreads, 2);
    set_deq(32'h400);
    cmp("cfg");
    // R6/R8: fill through all segments until the last slot
    for (int k = 1; k <= 7; k++) send(k, 0);
    chk("R8 full at next-segment base", sts_full, 1);
    send(8, 0);
    set_deq(32'h410);
    cmp("deq1");
    send(9, 0);
    chk("R6 phase toggled on wrap", sts_phase, 0);
    send(10, 0);
    set_deq(32'h400);
    cmp("deq2");
    send(11, 0);
    // R11: write error
    send(12, 1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    m_errmem = 0;
    cmp("clr1");
    for (int k = 13; k <= 16; k++) send(k, 0);
    // R10: shrink below current index
    chk("R10 at segment 2", sts_enq, 32'hC00);
    set_size(1);
    cmp("badidx");
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    m_erridx = 0;
    cmp("clr2");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule